// File: doc/BRIEF.md
# Lite UART register block

This block is a small bus-slave peripheral that a processor uses to move bytes to and from a serial channel. It has four 32-bit registers. The word index is the byte address shifted right by two. Reading the receive-data word takes the oldest byte out of an eight-entry receive FIFO. Writing the transmit-data word sends its low byte out as a one-cycle strobe. The status word can only be read. It reports the FIFO state and a sticky interrupt-pending flag. The control word empties the receive FIFO and enables the interrupt output.

On the line side, incoming bytes arrive through a valid/ready handshake. Ready falls while the FIFO is full, so a byte offered then is not taken. Outgoing bytes leave as a valid pulse with a data byte. The transmitter never queues anything, so it always reports empty. Bit timing, baud generation, framing and parity checking belong to other blocks. The overrun, frame and parity status bits therefore always read zero.

A bus access is presented for one cycle on the request pins. Its response (read data and error flag) appears in the cycle after it and lasts for that single cycle.

Top module: `lite_uart_regs`

## Requirements
- R1: After reset, irq, tx_valid, rsp_err and rsp_rdata are 0 and rx_ready is 1. The status word reads 0x04 and the control word reads 0.
- R2: Word index = req_addr >> 2: 0 receive data, 1 transmit data, 2 status, 3 control. The response is on rsp_rdata/rsp_err one cycle after the request. An index of 4 or more reads 0 and a write to it changes nothing. A write to index 0 changes nothing.
- R3: A read of index 0 returns the oldest stored byte in bits 7:0 (upper bits 0) and removes it. A read with the FIFO empty leaves the occupancy at 0 and status bit 0 at 0.
- R4: The FIFO holds 8 bytes. rx_ready is 0 exactly while 8 are held, and status bit 1 is then 1. A byte offered while full is not stored.
- R5: A control write stores the full 32-bit value, which reads back unchanged. If bit 1 is set, the FIFO is emptied, and a byte pushed in that same cycle is discarded.
- R6: A transmit write makes tx_valid 1 for exactly the next cycle with tx_data equal to bits 7:0 of the write. Index 1 reads back the last value written. tx_valid is 0 in every other cycle.
- R7: Status bit 4 (interrupt pending) becomes 1 after any cycle that leaves the FIFO non-empty and after any transmit write. It stays 1 until it is cleared.
- R8: A status read returns the pending bit as it was before the read, then clears it, unless the FIFO is non-empty after that cycle.
- R9: irq equals the pending bit AND control bit 4.
- R10: Status bit 2 always reads 1. Bit 0 is 1 when the FIFO is non-empty. Bits 3 and 5 to 31 read 0.
- R11: A write to the status word changes no register and gives rsp_err = 1. Every other access gives rsp_err = 0.
- R12: A push and a receive read in the same cycle, with 1 to 7 bytes held, both take effect. The read returns the previous oldest byte and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the cycle after a read |
| rsp_err | output | 1 | Bus error, one cycle after a status write |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the relations that must hold in every cycle. These are: the occupancy bound and the matching ready level, the link between pending and a non-empty FIFO, and the gating of irq by the enable bit. They also check the transmit strobe timing, the error response to a status write, the clear-on-reset-bit behaviour and the unchanged occupancy under a simultaneous push and pop. FIFO ordering across fills of every length from empty to past full can only be seen in the bench's scenarios. The same holds for the values read back from an empty FIFO, for the order of read-then-clear of the pending flag, and for the rule that an unmapped or receive-index write leaves the registers unchanged.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_RXDATA  = 2'd0,
        SEL_TXDATA  = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_CONTROL = 2'd3
    } reg_sel_e;

    // status bit positions
    localparam int unsigned ST_RX_AVAIL = 0;
    localparam int unsigned ST_RX_FULL  = 1;
    localparam int unsigned ST_TX_EMPTY = 2;
    localparam int unsigned ST_IRQ_PEND = 4;

    // control bit positions
    localparam int unsigned CT_RX_RST   = 1;
    localparam int unsigned CT_IRQ_EN   = 4;

endpackage

// File: rtl/lu_rx_fifo.sv
module lu_rx_fifo #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              pop,
    input  logic              clr,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              nonempty_next
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push_ok;
    logic     pop_ok;
    logic [PTR_W-1:0] rd_idx;

    always_comb begin
        st_d       = st_q;
        full       = (st_q.cnt == CNT_W'(DEPTH));
        push_ready = !full;
        push_ok    = push_valid && !full;
        pop_ok     = pop && (st_q.cnt != '0);
        rd_idx     = st_q.wp - st_q.cnt[PTR_W-1:0];
        head_data  = st_q.mem[rd_idx];
        if (clr) begin
            st_d.wp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wp] = push_data;
                st_d.wp           = st_q.wp + PTR_W'(1);
            end
            st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
        nonempty_next = (st_d.cnt != '0);
        count         = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lu_csr.sv
module lu_csr
    import lu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  reg_sel_e          acc_sel,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic              rx_nonempty,
    input  logic              rx_full,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic              rx_nonempty_next,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq,
    output logic              irq_pend,
    output logic [WORD_W-1:0] ctrl_word
);

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] txr;
        logic              pend;
        logic              txv;
        logic [BYTE_W-1:0] txd;
        logic [WORD_W-1:0] rdata;
        logic              err;
    } csr_st_t;

    csr_st_t st_d, st_q;
    logic [WORD_W-1:0] status_word;

    always_comb begin
        status_word              = '0;
        status_word[ST_RX_AVAIL] = rx_nonempty;
        status_word[ST_RX_FULL]  = rx_full;
        status_word[ST_TX_EMPTY] = 1'b1;
        status_word[ST_IRQ_PEND] = st_q.pend;

        st_d       = st_q;
        st_d.txv   = 1'b0;
        st_d.err   = 1'b0;
        st_d.rdata = '0;
        if (acc_valid) begin
            if (acc_write) begin
                unique case (acc_sel)
                    SEL_TXDATA: begin
                        st_d.txr  = acc_wdata;
                        st_d.txv  = 1'b1;
                        st_d.txd  = acc_wdata[BYTE_W-1:0];
                        st_d.pend = 1'b1;
                    end
                    SEL_CONTROL: st_d.ctrl = acc_wdata;
                    SEL_STATUS:  st_d.err  = 1'b1;
                    default: ;
                endcase
            end else begin
                unique case (acc_sel)
                    SEL_RXDATA:  st_d.rdata = WORD_W'(rx_head);
                    SEL_TXDATA:  st_d.rdata = st_q.txr;
                    SEL_STATUS: begin
                        st_d.rdata = status_word;
                        st_d.pend  = 1'b0;
                    end
                    default:     st_d.rdata = st_q.ctrl;
                endcase
            end
        end
        if (rx_nonempty_next) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_rdata = st_q.rdata;
    assign rsp_err   = st_q.err;
    assign tx_valid  = st_q.txv;
    assign tx_data   = st_q.txd;
    assign irq_pend  = st_q.pend;
    assign ctrl_word = st_q.ctrl;
    assign irq       = st_q.pend && st_q.ctrl[CT_IRQ_EN];

endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
    import lu_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              irq
);

    logic [ADDR_W-1:0] word_idx;
    logic              in_map;
    logic              acc;
    reg_sel_e          sel;
    logic              rx_pop;
    logic              rx_clr;
    logic [BYTE_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_full;
    logic              rx_nonempty_next;
    logic              irq_pend;
    logic [WORD_W-1:0] ctrl_word;

    always_comb begin
        word_idx = req_addr >> 2;
        in_map   = (word_idx < ADDR_W'(4));
        sel      = reg_sel_e'(word_idx[1:0]);
        acc      = req_valid && in_map;
        rx_pop   = acc && !req_write && (sel == SEL_RXDATA);
        rx_clr   = acc && req_write && (sel == SEL_CONTROL) && req_wdata[CT_RX_RST];
    end

    lu_rx_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_valid    (rx_valid),
        .push_data     (rx_data),
        .push_ready    (rx_ready),
        .pop           (rx_pop),
        .clr           (rx_clr),
        .head_data     (rx_head),
        .count         (rx_count),
        .full          (rx_full),
        .nonempty_next (rx_nonempty_next)
    );

    lu_csr u_csr (
        .clk              (clk),
        .rst_n            (rst_n),
        .acc_valid        (acc),
        .acc_write        (req_write),
        .acc_sel          (sel),
        .acc_wdata        (req_wdata),
        .rx_nonempty      (rx_count != '0),
        .rx_full          (rx_full),
        .rx_head          (rx_head),
        .rx_nonempty_next (rx_nonempty_next),
        .rsp_rdata        (rsp_rdata),
        .rsp_err          (rsp_err),
        .tx_valid         (tx_valid),
        .tx_data          (tx_data),
        .irq              (irq),
        .irq_pend         (irq_pend),
        .ctrl_word        (ctrl_word)
    );

endmodule

// File: rtl/lu_checker.sv
module lu_checker #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_err,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              irq,
    input logic [CNT_W-1:0]  occ,
    input logic              pend,
    input logic [31:0]       ctrl
);

    logic [ADDR_W-1:0] widx;
    logic              hit;
    logic              wr_tx, wr_st, rd_rx, clr;

    always_comb begin
        widx  = req_addr >> 2;
        hit   = req_valid && (widx < ADDR_W'(4));
        wr_tx = hit && req_write && (widx[1:0] == 2'd1);
        wr_st = hit && req_write && (widx[1:0] == 2'd2);
        rd_rx = hit && !req_write && (widx[1:0] == 2'd0);
        clr   = hit && req_write && (widx[1:0] == 2'd3) && req_wdata[1];
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_full_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !rx_ready);

    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0));

    assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx |=> (tx_valid && tx_data == $past(req_wdata[7:0])));

    assert_tx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx |=> !tx_valid);

    assert_pend_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ != '0) |-> pend);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ctrl[4]));

    assert_status_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_st |=> (rsp_err && ctrl == $past(ctrl)));

    assert_push_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && rx_valid && rx_ready && occ != '0) |=> (occ == $past(occ)));

endmodule

bind lite_uart_regs lu_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_err   (rsp_err),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .occ       (rx_count),
    .pend      (irq_pend),
    .ctrl      (ctrl_word)
);

// File: tb/lite_uart_regs_bench.sv
module lite_uart_regs_bench;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              irq;

    always #5 clk = ~clk;

    lite_uart_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_lite_uart_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [7:0]  mq[$];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_txr  = '0;
    bit          m_pend = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [31:0] stat_exp();
        logic [31:0] s;
        s    = 32'h4;
        s[0] = (mq.size() > 0);
        s[1] = (mq.size() == DEPTH);
        s[4] = m_pend;
        return s;
    endfunction

    // one cycle: optional bus access and optional line-side push
    task automatic cycle(input bit acc, input bit wr, input logic [5:0] addr,
                         input logic [31:0] wd, input bit psh, input logic [7:0] pb,
                         input string tag);
        logic [31:0] exp_rd;
        bit chk_rd, exp_err, exp_txv, rdy, p, clr;
        logic [7:0] exp_txd;
        int idx;
        bit inm;
        idx = int'(addr[3:2]);
        inm = (addr[5:4] == 2'b00);
        @(negedge clk);
        req_valid = acc; req_write = wr; req_addr = addr; req_wdata = wd;
        rx_valid = psh; rx_data = pb;
        rdy = (mq.size() < DEPTH);
        if (psh) chk({tag, " R4 rx_ready"}, 32'(rx_ready), 32'(rdy));
        exp_rd = '0; chk_rd = acc && !wr; exp_err = 1'b0; exp_txv = 1'b0;
        exp_txd = '0; p = m_pend; clr = 1'b0;
        if (acc && inm) begin
            if (wr) begin
                case (idx)
                    1: begin m_txr = wd; exp_txv = 1'b1; exp_txd = wd[7:0]; p = 1'b1; end
                    2: exp_err = 1'b1;
                    3: begin m_ctrl = wd; clr = wd[1]; end
                    default: ;
                endcase
            end else begin
                case (idx)
                    0: if (mq.size() > 0) exp_rd = 32'(mq.pop_front()); else chk_rd = 1'b0;
                    1: exp_rd = m_txr;
                    2: begin exp_rd = stat_exp(); p = 1'b0; end
                    default: exp_rd = m_ctrl;
                endcase
            end
        end
        if (clr) mq.delete();
        else if (psh && rdy) mq.push_back(pb);
        if (mq.size() > 0) p = 1'b1;
        m_pend = p;
        @(negedge clk);
        req_valid = 1'b0; rx_valid = 1'b0;
        if (chk_rd) chk({tag, " R2 rdata"}, rsp_rdata, exp_rd);
        chk({tag, " R11 rsp_err"}, 32'(rsp_err), 32'(exp_err));
        chk({tag, " R6 tx_valid"}, 32'(tx_valid), 32'(exp_txv));
        if (exp_txv) chk({tag, " R6 tx_data"}, 32'(tx_data), 32'(exp_txd));
        chk({tag, " R9 irq"}, 32'(irq), 32'(m_pend && m_ctrl[4]));
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        cycle(1, 0, a, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
        cycle(1, 1, a, d, 0, 0, tag);
    endtask
    task automatic push(input logic [7:0] b, input string tag);
        cycle(0, 0, 0, 0, 1, b, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rsp_err", 32'(rsp_err), 0);
        chk("R1 rsp_rdata", rsp_rdata, 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);
        rst_n = 1'b1;
        rd(6'h08, "R1 R10 status");
        rd(6'h0C, "R1 R5 ctrl");

        // R3/R4/R10: fills of every length from empty to past full
        for (int n = 0; n <= DEPTH + 2; n++) begin
            wr(6'h0C, 32'h2, "R5 clear");
            for (int i = 0; i < n; i++) push(8'(n * 17 + i), "R4 fill");
            rd(6'h08, "R10 status");
            for (int i = 0; i <= n; i++) rd(6'h00, "R3 drain");
            rd(6'h08, "R3 empty status");
            rd(6'h08, "R8 cleared");
        end

        // R7/R8/R9: pending from transmit, cleared by status read
        wr(6'h0C, 32'h10, "R9 enable");
        wr(6'h04, 32'h1234_56A5, "R7 tx write");
        rd(6'h04, "R6 tx readback");
        rd(6'h08, "R8 status clears");
        rd(6'h08, "R8 status after clear");

        // R8: status read with data held keeps pending
        for (int i = 0; i < 3; i++) push(8'hC0 + 8'(i), "R7 push");
        rd(6'h08, "R8 nonempty keeps");

        // R12: push and pop together
        cycle(1, 0, 6'h00, 0, 1, 8'h5E, "R12 push+pop");
        rd(6'h08, "R12 status");

        // R11: status write
        wr(6'h08, 32'hFFFF_FFFF, "R11 status write");
        rd(6'h0C, "R11 ctrl unchanged");
        rd(6'h08, "R11 status unchanged");

        // R2: writes to rx index and out-of-map
        wr(6'h00, 32'hFF, "R2 rx write ignored");
        wr(6'h1C, 32'h0, "R2 unmapped write");
        rd(6'h10, "R2 unmapped read");
        rd(6'h0C, "R2 ctrl kept");
        rd(6'h00, "R2 R3 oldest");

        // R5: clear wins over same-cycle push
        cycle(1, 1, 6'h0C, 32'h12, 1, 8'h77, "R5 clear+push");
        rd(6'h08, "R5 status empty");
        rd(6'h00, "R3 empty read");
        rd(6'h0C, "R5 ctrl readback");

        // R9: pending with enable off, then on
        wr(6'h0C, 32'h0, "R9 disable");
        wr(6'h04, 32'h0000_003C, "R9 tx pend");
        wr(6'h0C, 32'hABCD_0010, "R9 enable late");
        rd(6'h0C, "R5 ctrl full word");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule